// File: doc/BRIEF.md
# Vector Lane Shift and Transpose Unit

This block rearranges the contents of two 256-bit vector operands. Each operand is treated as a row of packed elements, either sixteen 16-bit lanes or eight 32-bit lanes. A 2-bit operation code selects one of four operations. Two of them are logical shifts by an immediate amount. Each lane shifts on its own, so no bit moves from one lane into the next. The other two are pairwise interleaves, which combine the even-indexed elements, or the odd-indexed elements, of both operands into one destination vector.

A request is presented for one cycle with `in_valid` high. The result appears on `out_vec` one clock later, with `out_valid` high for that cycle. When no request arrives, the output register keeps its last value. Arithmetic and modular reduction live elsewhere in the vector datapath. This unit only moves bits.

Top module: `vec_permute_unit`

## Requirements
- R1: After reset `out_valid` is 0 and `out_vec` is all zeros. `out_valid` is high exactly in the cycle after each cycle in which `in_valid` was high, and low otherwise.
- R2: With `wide_sel`=0 the vectors hold sixteen 16-bit elements, and element k occupies bits [16k+15:16k]. With `wide_sel`=1 they hold eight 32-bit elements, and element k occupies bits [32k+31:32k].
- R3: `op_sel`=2'b00 shifts every element of `src_a` left by `shamt`. Bits that pass the top of an element are dropped, and vacated low bits become 0.
- R4: `op_sel`=2'b01 shifts every element of `src_a` right by `shamt` (logical). Vacated high bits become 0, and no bit enters the element below.
- R5: For either shift, a `shamt` of at least the element width (16 or 32; `shamt` spans 0 to 63) gives an all-zero result.
- R6: `op_sel`=2'b10 (even interleave): destination element 2i = `src_a` element 2i, and destination element 2i+1 = `src_b` element 2i.
- R7: `op_sel`=2'b11 (odd interleave): destination element 2i = `src_a` element 2i+1, and destination element 2i+1 = `src_b` element 2i+1.
- R8: In a cycle with `in_valid` low, `out_vec` keeps its previous value whatever the other inputs do.
- R9: `src_b` has no effect on a shift result, and `shamt` has no effect on an interleave result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| op_sel | input | 2 | 00 shift left, 01 shift right, 10 even interleave, 11 odd interleave |
| wide_sel | input | 1 | 0: 16-bit elements, 1: 32-bit elements |
| shamt | input | 6 | Shift amount |
| src_a | input | 256 | First source vector |
| src_b | input | 256 | Second source vector |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_vec | output | 256 | Registered result |

## Verification
The bench builds the unit with its default parameters: a 256-bit vector, 16- and 32-bit element views, and a 6-bit shift amount. Because the shift amount can reach 63, the bench can drive values that sit exactly at an element width and values well beyond it, and so reach the all-zero case of R5 in both views. The full vector gives eight interleave pairs in the narrow view and four in the wide view, so element 0 and the top element of each view are exercised. Bit patterns placed at the edges of elements show whether a shift leaks bits across an element boundary.

// File: rtl/vperm_pkg.sv
package vperm_pkg;

   typedef enum logic [1:0] {
      VP_SHL  = 2'b00,
      VP_SHR  = 2'b01,
      VP_EVEN = 2'b10,
      VP_ODD  = 2'b11
   } vperm_op_e;

endpackage

// File: rtl/vperm_lane_shift.sv
// Per-element logical shifter with no cross-element carry.
module vperm_lane_shift #(
   parameter int VEC_W   = 256,
   parameter int LANE_W  = 16,
   parameter int SHAMT_W = 6
) (
   input  logic               go_left,
   input  logic [SHAMT_W-1:0] amount,
   input  logic [VEC_W-1:0]   din,
   output logic [VEC_W-1:0]   dout
);
   localparam int NLANE = VEC_W / LANE_W;

   if (VEC_W % LANE_W != 0) begin : g_bad_div
      $error("vperm_lane_shift: VEC_W must be a multiple of LANE_W");
   end
   if ((2 ** SHAMT_W) <= LANE_W) begin : g_bad_amt
      $error("vperm_lane_shift: SHAMT_W too narrow to reach LANE_W");
   end

   logic too_far;
   assign too_far = (amount >= SHAMT_W'(LANE_W));

   for (genvar k = 0; k < NLANE; k++) begin : g_lane
      logic [LANE_W-1:0] lane_in, lane_out;
      assign lane_in = din[k*LANE_W +: LANE_W];
      always_comb begin
         if (too_far)
            lane_out = '0;
         else if (go_left)
            lane_out = lane_in << amount;
         else
            lane_out = lane_in >> amount;
      end
      assign dout[k*LANE_W +: LANE_W] = lane_out;
   end
endmodule

// File: rtl/vperm_interleave.sv
// Pairwise interleave of even or odd elements of two sources.
module vperm_interleave #(
   parameter int VEC_W  = 256,
   parameter int ELEM_W = 16
) (
   input  logic             pick_odd,
   input  logic [VEC_W-1:0] src_a,
   input  logic [VEC_W-1:0] src_b,
   output logic [VEC_W-1:0] dout
);
   localparam int NELEM = VEC_W / ELEM_W;
   localparam int NPAIR = NELEM / 2;

   if (VEC_W % (2 * ELEM_W) != 0) begin : g_bad_pairs
      $error("vperm_interleave: element count must be even");
   end

   for (genvar p = 0; p < NPAIR; p++) begin : g_pair
      localparam int LO = (2 * p) * ELEM_W;
      localparam int HI = (2 * p + 1) * ELEM_W;
      assign dout[LO +: ELEM_W] = pick_odd ? src_a[HI +: ELEM_W] : src_a[LO +: ELEM_W];
      assign dout[HI +: ELEM_W] = pick_odd ? src_b[HI +: ELEM_W] : src_b[LO +: ELEM_W];
   end
endmodule

// File: rtl/vperm_out_stage.sv
// Result register with valid strobe; holds when idle.
module vperm_out_stage #(
   parameter int VEC_W = 256
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [VEC_W-1:0] din,
   output logic             valid,
   output logic [VEC_W-1:0] dout
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid <= 1'b0;
         dout  <= '0;
      end else begin
         valid <= load;
         if (load) dout <= din;
      end
   end
endmodule

// File: rtl/vec_permute_unit.sv
module vec_permute_unit
   import vperm_pkg::*;
#(
   parameter int VEC_W   = 256,
   parameter int NARW_W  = 16,
   parameter int WIDE_W  = 32,
   parameter int SHAMT_W = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [1:0]         op_sel,
   input  logic               wide_sel,
   input  logic [SHAMT_W-1:0] shamt,
   input  logic [VEC_W-1:0]   src_a,
   input  logic [VEC_W-1:0]   src_b,
   output logic               out_valid,
   output logic [VEC_W-1:0]   out_vec
);
   localparam int NVIEW = 2;

   if (WIDE_W <= NARW_W) begin : g_bad_views
      $error("vec_permute_unit: WIDE_W must exceed NARW_W");
   end

   vperm_op_e op;
   assign op = vperm_op_e'(op_sel);

   logic go_left, pick_odd, is_shift;
   assign go_left  = (op == VP_SHL);
   assign pick_odd = (op == VP_ODD);
   assign is_shift = (op == VP_SHL) || (op == VP_SHR);

   logic [VEC_W-1:0] shf_res [NVIEW];
   logic [VEC_W-1:0] trn_res [NVIEW];

   for (genvar v = 0; v < NVIEW; v++) begin : g_view
      localparam int EW = (v == 0) ? NARW_W : WIDE_W;
      vperm_lane_shift #(.VEC_W(VEC_W), .LANE_W(EW), .SHAMT_W(SHAMT_W)) u_shf (
         .go_left (go_left),
         .amount  (shamt),
         .din     (src_a),
         .dout    (shf_res[v])
      );
      vperm_interleave #(.VEC_W(VEC_W), .ELEM_W(EW)) u_trn (
         .pick_odd (pick_odd),
         .src_a    (src_a),
         .src_b    (src_b),
         .dout     (trn_res[v])
      );
   end

   logic [VEC_W-1:0] nxt;
   always_comb begin
      if (is_shift) nxt = shf_res[wide_sel];
      else          nxt = trn_res[wide_sel];
   end

   vperm_out_stage #(.VEC_W(VEC_W)) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (in_valid),
      .din   (nxt),
      .valid (out_valid),
      .dout  (out_vec)
   );

   // R1
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   // R1
   valid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   // R8
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_vec));
   // R5
   far_shift_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (op_sel[1] == 1'b0) &&
       (shamt >= (wide_sel ? SHAMT_W'(WIDE_W) : SHAMT_W'(NARW_W)))) |=> (out_vec == '0));
   // R6
   even_pair0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_sel == 2'b10 && !wide_sel) |=>
      (out_vec[NARW_W-1:0] == $past(src_a[NARW_W-1:0]) &&
       out_vec[2*NARW_W-1:NARW_W] == $past(src_b[NARW_W-1:0])));
   // R7
   odd_pair0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_sel == 2'b11 && wide_sel) |=>
      (out_vec[WIDE_W-1:0] == $past(src_a[2*WIDE_W-1:WIDE_W]) &&
       out_vec[2*WIDE_W-1:WIDE_W] == $past(src_b[2*WIDE_W-1:WIDE_W])));
endmodule

// File: tb/sim_vec_permute_unit.sv
`timescale 1ns/1ps
module sim_vec_permute_unit;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [1:0]   op_sel = 2'b00;
   logic         wide_sel = 1'b0;
   logic [5:0]   shamt = '0;
   logic [255:0] src_a = '0;
   logic [255:0] src_b = '0;
   logic         out_valid;
   logic [255:0] out_vec;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #10 clk = ~clk;

   vec_permute_unit u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
      .wide_sel(wide_sel), .shamt(shamt), .src_a(src_a), .src_b(src_b),
      .out_valid(out_valid), .out_vec(out_vec)
   );

   function automatic logic [255:0] rnd256();
      logic [255:0] r;
      for (int i = 0; i < 8; i++) r[i*32 +: 32] = $urandom;
      return r;
   endfunction

   // Independent model written from the requirements.
   function automatic logic [255:0] model(input logic [1:0] op, input logic wide,
                                          input int sh, input logic [255:0] a,
                                          input logic [255:0] b);
      int lw;
      int n;
      logic [255:0] mask, res, e;
      lw   = wide ? 32 : 16;
      n    = 256 / lw;
      mask = wide ? 256'hFFFF_FFFF : 256'hFFFF;
      res  = '0;
      for (int k = 0; k < n; k++) begin
         if (op[1] == 1'b0) begin
            e = (a >> (k*lw)) & mask;
            if (sh >= lw) e = '0;
            else if (op == 2'b00) e = (e << sh) & mask;
            else e = e >> sh;
         end else begin
            int j;
            j = (k & ~1) + (op == 2'b11 ? 1 : 0);
            e = (((k % 2) == 0 ? a : b) >> (j*lw)) & mask;
         end
         res = res | (e << (k*lw));
      end
      return res;
   endfunction

   task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   // Drive one request, then sample the result at the following falling edge.
   task automatic issue(input logic [1:0] op, input logic wide, input logic [5:0] sh,
                        input logic [255:0] a, input logic [255:0] b);
      @(negedge clk);
      in_valid = 1'b1; op_sel = op; wide_sel = wide; shamt = sh; src_a = a; src_b = b;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 reset valid", {255'b0, out_valid}, '0);
      chk("R1 reset data", out_vec, '0);
   endtask

   task automatic t_valid_timing();
      issue(2'b00, 1'b0, 6'd1, 256'h1, '0);
      chk("R1 valid after request", {255'b0, out_valid}, 256'h1);
      @(negedge clk);
      chk("R1 valid drops", {255'b0, out_valid}, '0);
   endtask

   task automatic t_shl_narrow();
      issue(2'b00, 1'b0, 6'd4, {16{16'hF00F}}, rnd256());
      chk("R3 R2 shl16 edge bits dropped", out_vec, {16{16'h00F0}});
      for (int i = 0; i < 3; i++) begin
         logic [255:0] a;
         logic [5:0] s;
         a = rnd256(); s = 6'($urandom_range(0, 15));
         issue(2'b00, 1'b0, s, a, rnd256());
         chk("R3 shl16 random", out_vec, model(2'b00, 1'b0, s, a, '0));
      end
   endtask

   task automatic t_shr_wide();
      issue(2'b01, 1'b1, 6'd8, {8{32'h1234_5678}}, '0);
      chk("R4 R2 shr32 no cross", out_vec, {8{32'h0012_3456}});
      issue(2'b01, 1'b0, 6'd1, {16{16'h0001}}, '0);
      chk("R4 shr16 low bit lost", out_vec, '0);
      issue(2'b00, 1'b1, 6'd31, {8{32'h0000_0003}}, '0);
      chk("R3 shl32 by 31", out_vec, {8{32'h8000_0000}});
      for (int i = 0; i < 3; i++) begin
         logic [255:0] a;
         logic [5:0] s;
         a = rnd256(); s = 6'($urandom_range(0, 31));
         issue(2'b01, 1'b1, s, a, rnd256());
         chk("R4 shr32 random", out_vec, model(2'b01, 1'b1, s, a, '0));
      end
   endtask

   task automatic t_shift_far();
      issue(2'b00, 1'b0, 6'd16, {256{1'b1}}, '0);
      chk("R5 shl16 by 16", out_vec, '0);
      issue(2'b01, 1'b0, 6'd15, {256{1'b1}}, '0);
      chk("R5 shr16 by 15 keeps one bit", out_vec, {16{16'h0001}});
      issue(2'b01, 1'b1, 6'd32, {256{1'b1}}, '0);
      chk("R5 shr32 by 32", out_vec, '0);
      issue(2'b00, 1'b1, 6'd63, {256{1'b1}}, '0);
      chk("R5 shl32 by 63", out_vec, '0);
      issue(2'b00, 1'b1, 6'd20, {256{1'b1}}, '0);
      chk("R5 R2 shl32 by 20 not zero", out_vec, {8{32'hFFF0_0000}});
   endtask

   task automatic t_even();
      logic [255:0] a, b, e;
      for (int k = 0; k < 16; k++) begin
         a[k*16 +: 16] = 16'(k);
         b[k*16 +: 16] = 16'(16'h100 + k);
      end
      for (int i = 0; i < 8; i++) begin
         e[(2*i)*16 +: 16]   = 16'(2*i);
         e[(2*i+1)*16 +: 16] = 16'(16'h100 + 2*i);
      end
      issue(2'b10, 1'b0, 6'd0, a, b);
      chk("R6 even16 indexed", out_vec, e);
      a = rnd256(); b = rnd256();
      issue(2'b10, 1'b1, 6'd0, a, b);
      chk("R6 even32 random", out_vec, model(2'b10, 1'b1, 0, a, b));
   endtask

   task automatic t_odd();
      logic [255:0] a, b, e;
      for (int k = 0; k < 8; k++) begin
         a[k*32 +: 32] = 32'hA000_0000 + k;
         b[k*32 +: 32] = 32'hB000_0000 + k;
      end
      for (int i = 0; i < 4; i++) begin
         e[(2*i)*32 +: 32]   = 32'hA000_0000 + 2*i + 1;
         e[(2*i+1)*32 +: 32] = 32'hB000_0000 + 2*i + 1;
      end
      issue(2'b11, 1'b1, 6'd0, a, b);
      chk("R7 odd32 indexed", out_vec, e);
      a = rnd256(); b = rnd256();
      issue(2'b11, 1'b0, 6'd0, a, b);
      chk("R7 odd16 random", out_vec, model(2'b11, 1'b0, 0, a, b));
   endtask

   task automatic t_hold();
      logic [255:0] a, snap;
      a = rnd256();
      issue(2'b01, 1'b0, 6'd3, a, '0);
      snap = out_vec;
      chk("R8 before idle", snap, model(2'b01, 1'b0, 3, a, '0));
      @(negedge clk);
      op_sel = 2'b10; src_a = rnd256(); src_b = rnd256(); shamt = 6'd9; wide_sel = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk("R8 held while idle", out_vec, snap);
   endtask

   task automatic t_ignored();
      logic [255:0] a, b, r1;
      a = rnd256(); b = rnd256();
      issue(2'b00, 1'b1, 6'd5, a, '0);
      r1 = out_vec;
      issue(2'b00, 1'b1, 6'd5, a, ~b);
      chk("R9 src_b ignored by shift", out_vec, r1);
      issue(2'b10, 1'b0, 6'd0, a, b);
      r1 = out_vec;
      issue(2'b10, 1'b0, 6'd47, a, b);
      chk("R9 shamt ignored by interleave", out_vec, r1);
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog expired act=running exp=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_valid_timing();
      t_shl_narrow();
      t_shr_wide();
      t_shift_far();
      t_even();
      t_odd();
      t_hold();
      t_ignored();
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule